// File: doc/BRIEF.md
# Seconds-Nanoseconds Time-of-Day Clock with Sub-Nanosecond Trim

This block keeps a free-running time of day in three 32-bit words: whole seconds, nanoseconds within the second, and a residue in units of 2^-32 ns. On every clock edge it advances by a fixed base step of 12.5 ns. A signed trim value is added to that step. The trim has a sign bit and a 31-bit magnitude, so each step stays between 12 ns and 13 ns. The residue carries into nanoseconds. When nanoseconds reach one billion they fold back and seconds go up by one. Seconds wrap silently at 2^32, which is roughly 136 years.

Software sets the rate through the trim word and sets the time through a load strobe. It reads the three words through a small registered read port. Reading the residue captures the nanoseconds and seconds at the same instant. Later reads of those two words return the captured values, so a sequence of three reads always gives one coherent time. The step size is constant. It does not depend on any link rate or any other outside condition.

Top module: `tod_clock`

## Requirements
- R1: While `rst_ni` is low, all time words, the trim word, `rd_data_o` and `rd_valid_o` are zero. After reset, a read of the trim word returns 0.
- R2: On every edge with no load, the time advances by 12.5 ns plus the trim. Nanoseconds grow by 12 or 13 (modulo 1e9). With zero trim, the residue alternates between 0 and 0x8000_0000.
- R3: The residue is a 32-bit fraction of a nanosecond. A carry out of it adds one to nanoseconds, and the result stays exact over thousands of steps.
- R4: When trim bit 31 is 0, bits 30:0 are added to the step in units of 2^-32 ns.
- R5: When trim bit 31 is 1, bits 30:0 are subtracted from the step. A trim of 0x8000_0000 acts as zero.
- R6: Nanoseconds never reach 1,000,000,000. A step that would reach or pass that value subtracts one billion and adds one to seconds.
- R7: Seconds wrap from 0xFFFF_FFFF to 0 on a nanosecond rollover.
- R8: When `load_i` is high at an edge, seconds take `load_sec_i`, nanoseconds take `load_ns_i` (which must be below 1e9), and the residue clears. The load takes priority over that cycle's step, and stepping resumes on the next edge.
- R9: A read with select 0 returns the residue and captures nanoseconds and seconds at the same edge. Reads with select 1 (nanoseconds) and select 2 (seconds) return the captured values, however many cycles later they occur.
- R10: `rd_data_o` and `rd_valid_o` are registered. They appear one cycle after `rd_en_i` is sampled. Select 3 returns the trim word.
- R11: A trim write takes effect on the step of the edge after the edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one step per rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trim_we_i | input | 1 | Write strobe for the trim word |
| trim_i | input | 32 | Trim: bit 31 sign, bits 30:0 magnitude in 2^-32 ns |
| load_i | input | 1 | Time-load strobe |
| load_sec_i | input | 32 | Seconds value for a load |
| load_ns_i | input | 32 | Nanoseconds value for a load |
| rd_en_i | input | 1 | Read request |
| rd_sel_i | input | 2 | Read select: 0 residue, 1 ns, 2 seconds, 3 trim |
| rd_data_o | output | 32 | Read data, one cycle after the request |
| rd_valid_o | output | 1 | Read data valid |

## Verification
The assertions check four things on every cycle. Nanoseconds stay below one billion. Each unloaded step moves nanoseconds forward by 12 or 13, and seconds rise exactly when nanoseconds fold back. A load lands exactly in the following cycle with the residue cleared. Read-valid follows the request by one cycle. The exact sub-nanosecond arithmetic of positive and negative trims, the seconds wrap at 2^32 and the coherence of captured reads can only be shown by the bench. The bench compares every read against a single wide-integer count of 2^-32 ns units, swept over trims at both extremes and over loads placed just below the rollover.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [1:0] {
    RD_FRAC = 2'd0,
    RD_NS   = 2'd1,
    RD_SEC  = 2'd2,
    RD_TRIM = 2'd3
  } rd_sel_e;

  typedef struct packed {
    logic [WORD_W-1:0] sec;
    logic [WORD_W-1:0] ns;
    logic [WORD_W-1:0] frac;
  } tod_t;
endpackage

// File: rtl/tod_step_gen.sv
module tod_step_gen #(
  parameter int unsigned NS_W      = 32,
  parameter int unsigned FRAC_W    = 32,
  parameter int unsigned TRIM_W    = 32,
  parameter logic [63:0] BASE_STEP = 64'h0000_000C_8000_0000
) (
  input  logic [TRIM_W-1:0]      trim_i,
  output logic [NS_W+FRAC_W-1:0] step_o
);
  localparam int unsigned STEP_W = NS_W + FRAC_W;
  localparam int unsigned MAG_W  = TRIM_W - 1;

  logic [STEP_W-1:0] base;
  logic [STEP_W-1:0] mag;
  logic              neg;

  assign base = STEP_W'(BASE_STEP);
  assign mag  = STEP_W'(trim_i[MAG_W-1:0]);
  assign neg  = trim_i[TRIM_W-1];

  // sign-magnitude trim around the base period
  always_comb begin
    if (neg) step_o = base - mag;
    else     step_o = base + mag;
  end
endmodule

// File: rtl/tod_accum.sv
module tod_accum #(
  parameter int unsigned SEC_W      = 32,
  parameter int unsigned NS_W       = 32,
  parameter int unsigned FRAC_W     = 32,
  parameter int unsigned NS_PER_SEC = 1_000_000_000
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NS_W+FRAC_W-1:0] step_i,
  input  logic                   load_i,
  input  logic [SEC_W-1:0]       load_sec_i,
  input  logic [NS_W-1:0]        load_ns_i,
  output logic [SEC_W-1:0]       sec_o,
  output logic [NS_W-1:0]        ns_o,
  output logic [FRAC_W-1:0]      frac_o
);
  localparam int unsigned        FIX_W   = NS_W + FRAC_W;
  localparam logic [NS_W-1:0]    NS_WRAP = NS_W'(NS_PER_SEC);

  logic [SEC_W-1:0]  sec_q, sec_n;
  logic [NS_W-1:0]   ns_q, ns_n, ns_raw;
  logic [FRAC_W-1:0] frac_q, frac_n;
  logic [FIX_W-1:0]  fix_sum;
  logic              roll;

  // {ns, frac} as one fixed-point word; frac carry lands in ns
  assign fix_sum = {ns_q, frac_q} + step_i;
  assign ns_raw  = fix_sum[FIX_W-1:FRAC_W];
  assign roll    = (ns_raw >= NS_WRAP);

  always_comb begin
    if (load_i) begin
      sec_n  = load_sec_i;
      ns_n   = load_ns_i;
      frac_n = '0;
    end else begin
      frac_n = fix_sum[FRAC_W-1:0];
      ns_n   = roll ? (ns_raw - NS_WRAP) : ns_raw;
      sec_n  = sec_q + SEC_W'(roll);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q  <= '0;
      ns_q   <= '0;
      frac_q <= '0;
    end else begin
      sec_q  <= sec_n;
      ns_q   <= ns_n;
      frac_q <= frac_n;
    end
  end

  assign sec_o  = sec_q;
  assign ns_o   = ns_q;
  assign frac_o = frac_q;
endmodule

// File: rtl/tod_rd_port.sv
module tod_rd_port
  import tod_pkg::*;
#(
  parameter int unsigned SEC_W  = 32,
  parameter int unsigned NS_W   = 32,
  parameter int unsigned FRAC_W = 32,
  parameter int unsigned TRIM_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic [1:0]        rd_sel_i,
  input  logic [SEC_W-1:0]  sec_i,
  input  logic [NS_W-1:0]   ns_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic [TRIM_W-1:0] trim_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o
);
  logic [SEC_W-1:0]  snap_sec_q;
  logic [NS_W-1:0]   snap_ns_q;
  logic [DATA_W-1:0] rd_mux;
  rd_sel_e           sel;

  assign sel = rd_sel_e'(rd_sel_i);

  always_comb begin
    unique case (sel)
      RD_FRAC: rd_mux = DATA_W'(frac_i);
      RD_NS:   rd_mux = DATA_W'(snap_ns_q);
      RD_SEC:  rd_mux = DATA_W'(snap_sec_q);
      default: rd_mux = DATA_W'(trim_i);
    endcase
  end

  // residue read freezes the upper words for the following reads
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_sec_q <= '0;
      snap_ns_q  <= '0;
    end else if (rd_en_i && (sel == RD_FRAC)) begin
      snap_sec_q <= sec_i;
      snap_ns_q  <= ns_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rd_data_o <= rd_mux;
    end
  end
endmodule

// File: rtl/tod_clock.sv
module tod_clock #(
  parameter int unsigned SEC_W      = 32,
  parameter int unsigned NS_W       = 32,
  parameter int unsigned FRAC_W     = 32,
  parameter int unsigned TRIM_W     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned NS_PER_SEC = 1_000_000_000,
  parameter logic [63:0] BASE_STEP  = 64'h0000_000C_8000_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trim_we_i,
  input  logic [TRIM_W-1:0] trim_i,
  input  logic              load_i,
  input  logic [SEC_W-1:0]  load_sec_i,
  input  logic [NS_W-1:0]   load_ns_i,
  input  logic              rd_en_i,
  input  logic [1:0]        rd_sel_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o
);
  localparam int unsigned STEP_W = NS_W + FRAC_W;

  logic [TRIM_W-1:0] trim_q;
  logic [STEP_W-1:0] step_w;
  logic [SEC_W-1:0]  sec_w;
  logic [NS_W-1:0]   ns_w;
  logic [FRAC_W-1:0] frac_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        trim_q <= '0;
    else if (trim_we_i) trim_q <= trim_i;
  end

  tod_step_gen #(
    .NS_W(NS_W), .FRAC_W(FRAC_W), .TRIM_W(TRIM_W), .BASE_STEP(BASE_STEP)
  ) u_step (
    .trim_i (trim_q),
    .step_o (step_w)
  );

  tod_accum #(
    .SEC_W(SEC_W), .NS_W(NS_W), .FRAC_W(FRAC_W), .NS_PER_SEC(NS_PER_SEC)
  ) u_accum (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (step_w),
    .load_i     (load_i),
    .load_sec_i (load_sec_i),
    .load_ns_i  (load_ns_i),
    .sec_o      (sec_w),
    .ns_o       (ns_w),
    .frac_o     (frac_w)
  );

  tod_rd_port #(
    .SEC_W(SEC_W), .NS_W(NS_W), .FRAC_W(FRAC_W), .TRIM_W(TRIM_W), .DATA_W(DATA_W)
  ) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_en_i    (rd_en_i),
    .rd_sel_i   (rd_sel_i),
    .sec_i      (sec_w),
    .ns_i       (ns_w),
    .frac_i     (frac_w),
    .trim_i     (trim_q),
    .rd_data_o  (rd_data_o),
    .rd_valid_o (rd_valid_o)
  );
endmodule

// File: rtl/tod_clock_chk.sv
module tod_clock_chk #(
  parameter int unsigned SEC_W      = 32,
  parameter int unsigned NS_W       = 32,
  parameter int unsigned FRAC_W     = 32,
  parameter int unsigned NS_PER_SEC = 1_000_000_000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_i,
  input logic [SEC_W-1:0]  load_sec_i,
  input logic [NS_W-1:0]   load_ns_i,
  input logic              rd_en_i,
  input logic              rd_valid_o,
  input logic [SEC_W-1:0]  sec_w,
  input logic [NS_W-1:0]   ns_w,
  input logic [FRAC_W-1:0] frac_w
);
  localparam logic [NS_W:0] NS_WRAP = (NS_W+1)'(NS_PER_SEC);

  logic              started;
  logic              prev_load, prev_rd_en;
  logic [SEC_W-1:0]  prev_sec, prev_lsec;
  logic [NS_W-1:0]   prev_ns, prev_lns;
  logic [NS_W:0]     ns_delta;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started    <= 1'b0;
      prev_load  <= 1'b0;
      prev_rd_en <= 1'b0;
      prev_sec   <= '0;
      prev_lsec  <= '0;
      prev_ns    <= '0;
      prev_lns   <= '0;
    end else begin
      started    <= 1'b1;
      prev_load  <= load_i;
      prev_rd_en <= rd_en_i;
      prev_sec   <= sec_w;
      prev_lsec  <= load_sec_i;
      prev_ns    <= ns_w;
      prev_lns   <= load_ns_i;
    end
  end

  always_comb begin
    if (ns_w >= prev_ns) ns_delta = {1'b0, ns_w} - {1'b0, prev_ns};
    else                 ns_delta = {1'b0, ns_w} + NS_WRAP - {1'b0, prev_ns};
  end

  // R6
  ns_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, ns_w} < NS_WRAP);

  // R2
  ns_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started && !prev_load) |-> (ns_delta == 12 || ns_delta == 13));

  // R6 R7
  sec_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started && !prev_load) |-> (sec_w == prev_sec + SEC_W'(ns_w < prev_ns)));

  // R8
  load_apply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started && prev_load) |-> (sec_w == prev_lsec && ns_w == prev_lns && frac_w == '0));

  // R10
  rd_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started |-> (rd_valid_o == prev_rd_en));
endmodule

bind tod_clock tod_clock_chk #(
  .SEC_W(SEC_W), .NS_W(NS_W), .FRAC_W(FRAC_W), .NS_PER_SEC(NS_PER_SEC)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .load_i     (load_i),
  .load_sec_i (load_sec_i),
  .load_ns_i  (load_ns_i),
  .rd_en_i    (rd_en_i),
  .rd_valid_o (rd_valid_o),
  .sec_w      (sec_w),
  .ns_w       (ns_w),
  .frac_w     (frac_w)
);

// File: tb/tod_clock_bench.sv
`timescale 1ns/1ps
module tod_clock_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        trim_we_i = 1'b0;
  logic [31:0] trim_i = '0;
  logic        load_i = 1'b0;
  logic [31:0] load_sec_i = '0;
  logic [31:0] load_ns_i = '0;
  logic        rd_en_i = 1'b0;
  logic [1:0]  rd_sel_i = '0;
  logic [31:0] rd_data_o;
  logic        rd_valid_o;

  int n_run = 0;
  int n_fail = 0;
  string cur_tag = "R1";

  always #4 clk_i = ~clk_i;

  tod_clock u_tod_clock (
    .clk_i(clk_i), .rst_ni(rst_ni), .trim_we_i(trim_we_i), .trim_i(trim_i),
    .load_i(load_i), .load_sec_i(load_sec_i), .load_ns_i(load_ns_i),
    .rd_en_i(rd_en_i), .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o)
  );

  // reference: total time as one integer of 2^-32 ns units
  localparam logic [127:0] BILLION = 128'd1_000_000_000;
  localparam logic [127:0] MOD_T   = BILLION << 64;
  localparam logic [127:0] BASE    = 128'h0000_0000_0000_0000_0000_000C_8000_0000;

  logic [127:0] m_t;
  logic [31:0]  m_trim, m_snap_ns, m_snap_sec, exp_data;
  logic         exp_valid;

  function automatic logic [31:0] f_ns(input logic [127:0] t);
    return 32'((t >> 32) % BILLION);
  endfunction
  function automatic logic [31:0] f_sec(input logic [127:0] t);
    return 32'((t >> 32) / BILLION);
  endfunction
  function automatic logic [127:0] f_step(input logic [31:0] tr);
    logic [127:0] mag;
    mag = 128'(tr[30:0]);
    return tr[31] ? BASE - mag : BASE + mag;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_t <= '0; m_trim <= '0; m_snap_ns <= '0; m_snap_sec <= '0;
      exp_data <= '0; exp_valid <= 1'b0;
    end else begin
      if (load_i) m_t <= ((128'(load_sec_i) * BILLION) + 128'(load_ns_i)) << 32;
      else        m_t <= (m_t + f_step(m_trim)) % MOD_T;
      if (trim_we_i) m_trim <= trim_i;
      exp_valid <= rd_en_i;
      if (rd_en_i) begin
        case (rd_sel_i)
          2'd0: begin
            exp_data   <= m_t[31:0];
            m_snap_ns  <= f_ns(m_t);
            m_snap_sec <= f_sec(m_t);
          end
          2'd1:    exp_data <= m_snap_ns;
          2'd2:    exp_data <= m_snap_sec;
          default: exp_data <= m_trim;
        endcase
      end
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && (exp_valid || rd_valid_o)) begin
      n_run++;
      if (rd_valid_o !== exp_valid || rd_data_o !== exp_data) begin
        n_fail++;
        $display("FAIL %s (R10 read): valid=%0b data=%h expected valid=%0b data=%h",
                 cur_tag, rd_valid_o, rd_data_o, exp_valid, exp_data);
      end
    end
  end

  int cyc = 0;
  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: cycles=%0d expected below 150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr_trim(input logic [31:0] v);
    @(negedge clk_i); trim_we_i = 1'b1; trim_i = v;
    @(negedge clk_i); trim_we_i = 1'b0;
  endtask

  task automatic do_load(input logic [31:0] s, input logic [31:0] n);
    @(negedge clk_i); load_i = 1'b1; load_sec_i = s; load_ns_i = n;
    @(negedge clk_i); load_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel);
    @(negedge clk_i); rd_en_i = 1'b1; rd_sel_i = sel;
    @(negedge clk_i); rd_en_i = 1'b0;
  endtask

  task automatic rd3();
    rd(2'd0); rd(2'd1); rd(2'd2);
  endtask

  logic [31:0] trims [8] = '{32'h0000_0000, 32'h0000_0001, 32'h7FFF_FFFF, 32'h4000_0000,
                             32'h8000_0000, 32'h8000_0001, 32'hFFFF_FFFF, 32'hC000_0000};

  initial begin
    // R1: reset state at the ports
    idle(2);
    n_run++;
    if (rd_data_o !== 32'd0 || rd_valid_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: data=%h valid=%0b expected 0 0", rd_data_o, rd_valid_o);
    end
    @(negedge clk_i); rst_ni = 1'b1;
    cur_tag = "R1"; rd(2'd3);
    cur_tag = "R2"; idle(3); rd3(); rd(2'd0); rd(2'd0);
    // R11: trim write then immediate readback and stepping
    cur_tag = "R11"; wr_trim(32'h0000_1000); rd(2'd3); rd3();

    for (int i = 0; i < 8; i++) begin
      wr_trim(trims[i]);
      cur_tag = trims[i][31] ? "R5" : "R4";
      rd(2'd3);
      for (int k = 0; k < 5; k++) begin
        cur_tag = "R8"; do_load(32'd100 + 32'(k), 32'd999_999_990 - 32'(k));
        cur_tag = "R6"; idle(k); rd3();
        cur_tag = trims[i][31] ? "R5" : "R4"; idle(k); rd3();
      end
      // R9: captured words stay fixed while the clock keeps running
      cur_tag = "R9"; rd(2'd0); idle(7 + i); rd(2'd1); idle(3); rd(2'd2);
    end

    // R7: seconds wrap
    wr_trim(32'h0000_0000);
    cur_tag = "R7"; do_load(32'hFFFF_FFFF, 32'd999_999_980); idle(2); rd3();
    wr_trim(32'hFFFF_FFFF);
    do_load(32'hFFFF_FFFF, 32'd999_999_999); rd3();

    // R3: long run with fractional trim
    cur_tag = "R3"; wr_trim(32'h8001_2345); do_load(32'd7, 32'd0);
    idle(3000); rd3();
    wr_trim(32'h0ABC_DEF1); idle(5000); rd3();

    idle(4);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule